// File: doc/BRIEF.md
# Overlapping Windowed Integer Register File

This block is an integer register file arranged as a ring of overlapping register windows. Software sees 32 architectural registers through a 5-bit register number. Numbers 0 to 7 are globals, which are the same storage from every window. Numbers 8 to 15 are the window's outputs, 16 to 23 are its private locals, and 24 to 31 are its inputs. A current-window pointer picks the windowed bank. Physically each window owns only 16 registers, its inputs and its locals. A window's outputs are the very same storage as the inputs of the next window up the ring. A caller therefore places arguments in its outputs, and after a save the callee reads them as its inputs without any copy.

A save advances the pointer by one, modulo the window count. A restore steps it back. An occupancy counter records how many windows hold live state in the register file. Moving onto a window that would overwrite live data raises overflow, and moving below the last resident window raises underflow. In both cases the pointer stays where it is. The spill and fill work itself is done outside the block. External logic reports each completed spill or fill on a pulse input, and that pulse adjusts the occupancy. There are two combinational read ports and one write port, and a read of the register being written returns the new data in the same cycle.

Top module: `regwin_file`

## Requirements
- R1: After reset the current-window pointer is 0, overflow and underflow are low, and every architectural register reads zero on both read ports.
- R2: Register number 0 always reads zero, on both ports and also while it is being written; writes to it are dropped.
- R3: Registers 1 to 7 (globals) read the same value from every window.
- R4: Registers 16 to 23 (locals) are private: a value written in window w is still read in window w after every other window has written its own locals.
- R5: Output register 8+k written in window w is read as input register 24+k in window (w+1) mod NWIN, for k = 0..7.
- R6: An accepted save sets the pointer to (w+1) mod NWIN and an accepted restore sets it to (w-1+NWIN) mod NWIN, with the change visible after the next clock edge.
- R7: With NWIN-1 windows resident, save_req drives overflow high in the same cycle and the pointer does not move.
- R8: With a single window resident (as after reset), restore_req without save_req drives underflow high in the same cycle and the pointer does not move.
- R9: When a read port addresses the register being written in the same cycle (nonzero number), it returns the write data in that cycle.
- R10: When save_req and restore_req are both high, the save is taken and the restore is ignored.
- R11: A write issued in the same cycle as a save lands in the window that was current before the save.
- R12: A win_spilled pulse frees one resident window, which lets the next save proceed, and a win_filled pulse adds one, which lets the next restore proceed. Both pulses are acted on only in a cycle that has no save or restore request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Advance to the next window |
| restore_req | input | 1 | Return to the previous window |
| win_spilled | input | 1 | One resident window has been saved to memory |
| win_filled | input | 1 | One window has been reloaded from memory |
| cwp | output | clog2(NWIN) | Current-window pointer |
| overflow | output | 1 | Save refused: no free window |
| underflow | output | 1 | Restore refused: no resident window below |

## Verification
The bench runs on a four-window build. It walks the pointer twice round the ring with saves, and in each window it writes locals and outputs that encode the lap, the window and the slot. This separates a bank shared with the wrong neighbour from a bank that is private, because a wrong overlap shows up as another window's code on the inputs. The walk forces overflow, spill, wrap past the top window and a return to an earlier window. It then unwinds with restores through a wrap below window 0 into underflow and recovers with a fill. This tells the occupancy arithmetic apart from the pointer arithmetic. Single-cycle patterns then cover same-cycle forwarding, register 0, the save-over-restore priority and the window that receives a write issued together with a save.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int unsigned GLOBALS  = 8;
  localparam int unsigned PER_WIN  = 16;

  // Map an architectural register number onto a physical slot.
  // Layout: slots 0..7 globals, then per window 16 slots: inputs then locals.
  function automatic int unsigned phys_slot(input logic [4:0] areg,
                                            input int unsigned win,
                                            input int unsigned nwin);
    int unsigned base;
    int unsigned nxt;
    int unsigned slot;
    base = GLOBALS + PER_WIN * win;
    nxt  = (win + 1) % nwin;
    case (areg[4:3])
      2'd0:    slot = int'(areg[2:0]);
      2'd1:    slot = GLOBALS + PER_WIN * nxt + int'(areg[2:0]);
      2'd2:    slot = base + 8 + int'(areg[2:0]);
      default: slot = base + int'(areg[2:0]);
    endcase
    return slot;
  endfunction

  // Ring step of the window pointer.
  function automatic int unsigned ring_step(input int unsigned win,
                                            input int unsigned nwin,
                                            input logic up);
    if (up) return (win == nwin - 1) ? 0 : win + 1;
    return (win == 0) ? nwin - 1 : win - 1;
  endfunction

endpackage

// File: rtl/regwin_ptr.sv
module regwin_ptr
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int OW   = $clog2(NWIN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          restore_req,
  input  logic          win_spilled,
  input  logic          win_filled,
  output logic [CW-1:0] cwp,
  output logic          overflow,
  output logic          underflow
);

  logic [OW-1:0] occ;
  logic          full, single;
  logic          do_save, do_restore, do_spill, do_fill, quiet;

  assign full       = (occ == OW'(NWIN - 1));
  assign single     = (occ == OW'(1));
  assign quiet      = !save_req && !restore_req;
  assign do_save    = save_req && !full;
  assign do_restore = restore_req && !save_req && !single;
  assign do_spill   = win_spilled && quiet && !single;
  assign do_fill    = win_filled && quiet && !full;
  assign overflow   = save_req && full;
  assign underflow  = restore_req && !save_req && single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= '0;
      occ <= OW'(1);
    end else begin
      if (do_save) begin
        cwp <= CW'(ring_step(int'(cwp), NWIN, 1'b1));
        occ <= occ + 1'b1;
      end else if (do_restore) begin
        cwp <= CW'(ring_step(int'(cwp), NWIN, 1'b0));
        occ <= occ - 1'b1;
      end else if (do_spill) begin
        occ <= occ - 1'b1;
      end else if (do_fill) begin
        occ <= occ + 1'b1;
      end
    end
  end

  // R7
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(cwp));

  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(cwp));

  // R6
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !overflow) |=>
      ((cwp == $past(cwp) + 1'b1) || ($past(cwp) == CW'(NWIN - 1) && cwp == '0)));

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow, underflow}));

  // R12
  occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= OW'(1)) && (occ <= OW'(NWIN - 1)));

endmodule

// File: rtl/regwin_store.sv
module regwin_store
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cwp,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data
);

  localparam int NPHYS = GLOBALS + PER_WIN * NWIN;
  localparam int PW    = $clog2(NPHYS);

  logic [XLEN-1:0] regs [NPHYS];
  logic [PW-1:0]   slot_a, slot_b, slot_w;
  logic            wr_live;

  assign slot_a  = PW'(phys_slot(rd_a_idx, int'(cwp), NWIN));
  assign slot_b  = PW'(phys_slot(rd_b_idx, int'(cwp), NWIN));
  assign slot_w  = PW'(phys_slot(wr_idx,   int'(cwp), NWIN));
  assign wr_live = wr_en && (wr_idx != 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[slot_w] <= wr_data;
    end
  end

  always_comb begin
    if (rd_a_idx == 5'd0)                    rd_a_data = '0;
    else if (wr_live && slot_w == slot_a)    rd_a_data = wr_data;
    else                                     rd_a_data = regs[slot_a];
    if (rd_b_idx == 5'd0)                    rd_b_data = '0;
    else if (wr_live && slot_w == slot_b)    rd_b_data = wr_data;
    else                                     rd_b_data = regs[slot_b];
  end

  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  // R9
  fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 5'd0 && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data));

  // R9
  fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 5'd0 && rd_b_idx == wr_idx) |-> (rd_b_data == wr_data));

  // R3
  global_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_a_idx != 5'd0 && rd_a_idx[4:3] == 2'd0 && $stable(rd_a_idx))
      |=> (!$past(wr_en) && $past(rd_a_idx) == rd_a_idx) |-> $stable(rd_a_data));

endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            win_spilled,
  input  logic            win_filled,
  output logic [CW-1:0]   cwp,
  output logic            overflow,
  output logic            underflow
);

  logic [CW-1:0] cur_win;

  regwin_ptr #(.NWIN(NWIN), .CW(CW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .win_spilled (win_spilled),
    .win_filled  (win_filled),
    .cwp         (cur_win),
    .overflow    (overflow),
    .underflow   (underflow)
  );

  regwin_store #(.NWIN(NWIN), .XLEN(XLEN), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cwp       (cur_win),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  assign cwp = cur_win;

endmodule

// File: tb/regwin_file_tb.sv
module regwin_file_tb;

  localparam int CLK_P = 10;
  localparam int NW    = 4;
  localparam int XL    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [XL-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic          win_spilled = 1'b0, win_filled = 1'b0;
  logic [1:0]    cwp;
  logic          overflow, underflow;

  int n_chk = 0;
  int n_err = 0;
  int c = 0;
  int occ = 1;

  always #(CLK_P/2) clk = ~clk;

  regwin_file #(.NWIN(NW), .XLEN(XL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .win_spilled(win_spilled), .win_filled(win_filled),
    .cwp(cwp), .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [XL-1:0] lval(int lap, int w, int k);
    return 32'hA000 + lap * 32'h1000 + w * 16 + k;
  endfunction

  function automatic logic [XL-1:0] oval(int lap, int w, int k);
    return 32'hB000 + lap * 32'h1000 + w * 16 + k;
  endfunction

  task automatic chk(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [XL-1:0] exp);
    @(negedge clk);
    rd_a_idx = 5'(idx);
    rd_b_idx = 5'(idx);
    #1;
    chk(req, rd_a_data, exp);
    chk(req, rd_b_data, exp);
  endtask

  task automatic wr(input int idx, input logic [XL-1:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = val;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_save(input string req);
    @(negedge clk);
    save_req = 1'b1; #1;
    chk(req, {31'd0, overflow}, 32'd0);
    @(posedge clk); #1;
    save_req = 1'b0;
    c = (c + 1) % NW; occ++;
    chk(req, {30'd0, cwp}, c);
  endtask

  task automatic pulse_restore(input string req);
    @(negedge clk);
    restore_req = 1'b1; #1;
    chk(req, {31'd0, underflow}, 32'd0);
    @(posedge clk); #1;
    restore_req = 1'b0;
    c = (c + NW - 1) % NW; occ--;
    chk(req, {30'd0, cwp}, c);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 cwp", {30'd0, cwp}, 0);
    chk("R1 flags", {30'd0, overflow, underflow}, 0);
    for (int r = 0; r < 32; r++) rd_chk("R1 regs", r, 0);

    // R8 underflow at reset
    @(negedge clk);
    restore_req = 1'b1; #1;
    chk("R8 underflow", {31'd0, underflow}, 1);
    @(posedge clk); #1; restore_req = 1'b0;
    chk("R8 cwp held", {30'd0, cwp}, 0);

    // globals, and R2 write to r0 dropped
    for (int g = 1; g < 8; g++) wr(g, 32'h100 + g);
    wr(0, 32'hDEAD_BEEF);
    rd_chk("R2 r0", 0, 0);

    // two laps round the ring
    for (int lap = 0; lap < 2; lap++) begin
      for (int s = 0; s < NW; s++) begin
        int prev;
        for (int g = 1; g < 8; g++) rd_chk("R3 global", g, 32'h100 + g);
        if (lap == 1)
          for (int k = 0; k < 8; k++) rd_chk("R4 local kept", 16 + k, lval(0, c, k));
        for (int k = 0; k < 8; k++) wr(16 + k, lval(lap, c, k));
        for (int k = 0; k < 8; k++) wr(8 + k, oval(lap, c, k));
        if (occ == NW - 1) begin
          @(negedge clk);
          save_req = 1'b1; #1;
          chk("R7 overflow", {31'd0, overflow}, 1);
          @(posedge clk); #1; save_req = 1'b0;
          chk("R7 cwp held", {30'd0, cwp}, c);
          @(negedge clk); win_spilled = 1'b1;
          @(posedge clk); #1; win_spilled = 1'b0;
          occ--;
        end
        prev = c;
        pulse_save("R6 save");
        for (int k = 0; k < 8; k++) rd_chk("R5 overlap", 24 + k, oval(lap, prev, k));
      end
    end

    // unwind with restores (wraps below window 0)
    while (occ > 1) begin
      pulse_restore("R6 restore");
      for (int k = 0; k < 8; k++) rd_chk("R5 outs back", 8 + k, oval(1, c, k));
    end
    @(negedge clk);
    restore_req = 1'b1; #1;
    chk("R8 underflow", {31'd0, underflow}, 1);
    @(posedge clk); #1; restore_req = 1'b0;
    chk("R8 cwp held", {30'd0, cwp}, c);

    // R12 fill enables one more restore
    @(negedge clk); win_filled = 1'b1;
    @(posedge clk); #1; win_filled = 1'b0;
    occ++;
    pulse_restore("R12 fill");
    for (int k = 0; k < 8; k++) rd_chk("R12 outs", 8 + k, oval(1, c, k));

    // R9 same-cycle forwarding, R2 on the write port
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h1234_5678;
    rd_a_idx = 5'd17; rd_b_idx = 5'd17; #1;
    chk("R9 fwd A", rd_a_data, 32'h1234_5678);
    chk("R9 fwd B", rd_b_data, 32'h1234_5678);
    @(posedge clk); #1; wr_en = 1'b0;
    rd_chk("R9 stored", 17, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'h5555_AAAA;
    rd_a_idx = 5'd0; rd_b_idx = 5'd0; #1;
    chk("R2 fwd r0", rd_a_data, 0);
    @(posedge clk); #1; wr_en = 1'b0;
    rd_chk("R2 r0 after", 0, 0);

    // R10 save wins over restore (occ is 1, so a restore alone would underflow)
    @(negedge clk);
    save_req = 1'b1; restore_req = 1'b1; #1;
    chk("R10 no underflow", {30'd0, overflow, underflow}, 0);
    @(posedge clk); #1; save_req = 1'b0; restore_req = 1'b0;
    c = (c + 1) % NW; occ++;
    chk("R10 cwp", {30'd0, cwp}, c);

    // R11 write with save goes to old window
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd16; wr_data = 32'hC0FF_EE00; save_req = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0; save_req = 1'b0;
    c = (c + 1) % NW; occ++;
    chk("R11 cwp", {30'd0, cwp}, c);
    rd_chk("R11 new window untouched", 16, lval(1, c, 0));
    pulse_restore("R11 restore");
    rd_chk("R11 old window", 16, 32'hC0FF_EE00);

    finish_run();
  end

endmodule